// File: doc/BRIEF.md
# Scan-Chain Register Bank for a Hashing Job

This block is a small register file that a host reaches over a boundary-scan port through a single user data register. The test access controller sits outside the block. It hands over the capture, shift and update strobes for the data register, a flag that is high while the user instruction is selected, the serial input bit, and it takes the serial output bit. All strobes are one-cycle enables sampled on the block clock. Each shift strobe moves one bit.

The host sends two kinds of frame. A 38-bit write frame carries a value, an address and a write flag. A 6-bit read-request frame carries only an address with the flag cleared; the next scan then returns the 32-bit value of that address, least significant bit first. Every frame ends in an odd-parity bit, and any frame that fails the checks is dropped without side effects. Behind the addresses sit eleven job words for a hashing core, a clock-setting register, and a read port that pops the core's result FIFO.

The core pushes results into the FIFO. The block gives the core the job words, a one-cycle job-start pulse and a clock multiplier, and it keeps a saturating count of results lost to a full FIFO.

Top module: `jtagUserBank`

## Requirements
- R1: After reset all job words are zero, address 13 reads 200, `jobStart` is low, `dropCnt` is zero, and a pop of address 14 returns 32'hFFFFFFFF.
- R2: A 38-bit write frame holds data in bits 0..31, address in bits 32..35, write flag (1) in bit 36 and parity in bit 37, all LSB first. It stores the data in job word N for addresses 1..11, where word N is `jobWords[(N-1)*32 +: 32]`.
- R3: A 6-bit frame with address in bits 0..3, a cleared flag in bit 4 and parity in bit 5 selects the read address. The following scan shifts that register out on `tdo`, bit 0 first, starting right after capture.
- R4: The parity bit makes the count of ones in the whole frame odd. A frame with even parity has no effect: nothing is written, nothing is popped, and the read address is unchanged.
- R5: A good write to address 11 raises `jobStart` for exactly the one cycle after the update. Writes to other addresses leave it low.
- R6: A write of value V to address 13 is accepted only when 2 <= V <= 250. It sets `clkMult` to V>>1, and address 13 then reads `clkMult`*2. Out-of-range writes are ignored.
- R7: A good read request for address 14 pops the oldest FIFO entry, which the next scan returns. Entries come out in push order, and a pop of an empty FIFO returns 32'hFFFFFFFF.
- R8: Addresses 0, 12 and 15 read as zero. Writes to 0, 12, 14 and 15 change nothing.
- R9: A push into a full FIFO is dropped and increments `dropCnt`, which saturates at its maximum.
- R10: Only an update strobe acts on a frame. Shifted bits without an update, a scan length other than 6 or 38, and strobes while `userSel` is low have no effect.
- R11: A 38-bit frame with bit 36 clear, or a 6-bit frame with bit 4 set, is ignored even when its parity is good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| userSel | input | 1 | High while the user instruction is loaded |
| captureDr | input | 1 | Capture strobe for the data register |
| shiftDr | input | 1 | Shift strobe, one bit per cycle |
| updateDr | input | 1 | Update strobe that commits a frame |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| resValid | input | 1 | Result push strobe from the core |
| resData | input | 32 | Result word to push |
| jobWords | output | 352 | Job words 1..11, word N at bits (N-1)*32 upward |
| jobStart | output | 1 | One-cycle pulse after a write to address 11 |
| clkMult | output | 7 | Clock multiplier, frequency = 2*clkMult MHz |
| dropCnt | output | 8 | Saturating count of dropped pushes |

## Verification
A wrong bit in the shift register or bit counter shows up on the same scan. The frame is then dropped or misdecoded, and the next readback of the target address returns the old value. A FIFO pointer fault shows up on the first pop after it: results come out of order or lost, or the all-ones empty marker appears early, or the drop counter moves while there is still room. A corrupted read address or pop holding register shows up within one scan as a wrong `tdo` word.

// File: rtl/jubPkg.sv
package jubPkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 4;
  localparam int WR_LEN    = DATA_W + ADDR_W + 2;
  localparam int RD_LEN    = ADDR_W + 2;
  localparam int JOB_WORDS = 11;
  localparam logic [ADDR_W-1:0] ADDR_JOB_LO = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_JOB_HI = 4'd11;
  localparam logic [ADDR_W-1:0] ADDR_CLK    = 4'd13;
  localparam logic [ADDR_W-1:0] ADDR_POP    = 4'd14;
  localparam int CLK_MIN_MHZ = 2;
  localparam int CLK_MAX_MHZ = 250;
  localparam logic [6:0] CLK_RST_MULT = 7'd100;

  typedef struct packed {
    logic              wrEn;
    logic              rdReqEn;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } bankStrobeT;
endpackage

// File: rtl/jubFifo.sv
module jubFifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic              empty,
  output logic [DATA_W-1:0] head,
  output logic [DROP_W-1:0] dropCnt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic doPop, doPush, drop;

  assign empty  = (count == '0);
  assign head   = mem[rdPtr];
  assign doPop  = pop && !empty;
  assign doPush = push && ((count != CNT_FULL) || doPop);
  assign drop   = push && !doPush;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      dropCnt <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
      if (drop && (dropCnt != '1)) dropCnt <= dropCnt + 1'b1;
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_FULL);
  // R9
  drop_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    dropCnt >= $past(dropCnt));
  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/jubCtrl.sv
module jubCtrl
  import jubPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              userSel,
  input  logic              captureDr,
  input  logic              shiftDr,
  input  logic              updateDr,
  input  logic              tdi,
  input  logic [DATA_W-1:0] readWord,
  output logic              tdo,
  output bankStrobeT        strobe
);
  localparam int CNT_W = $clog2(WR_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_WR = CNT_W'(WR_LEN);
  localparam logic [CNT_W-1:0] CNT_RD = CNT_W'(RD_LEN);

  logic [WR_LEN-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [RD_LEN-1:0] rdFrame;
  logic updateHere, wrOk, rdOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (userSel) begin
      if (captureDr) begin
        shiftReg <= {{(WR_LEN-DATA_W){1'b0}}, readWord};
        bitCnt   <= '0;
      end else if (shiftDr) begin
        shiftReg <= {tdi, shiftReg[WR_LEN-1:1]};
        if (bitCnt != '1) bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // a short frame lands in the top bits of the right-shifting register
  assign rdFrame    = shiftReg[WR_LEN-1 -: RD_LEN];
  assign updateHere = userSel && updateDr;
  assign wrOk = updateHere && (bitCnt == CNT_WR) && shiftReg[WR_LEN-2] && (^shiftReg);
  assign rdOk = updateHere && (bitCnt == CNT_RD) && !rdFrame[ADDR_W] && (^rdFrame);

  always_comb begin
    strobe.wrEn    = wrOk;
    strobe.rdReqEn = rdOk;
    strobe.addr    = wrOk ? shiftReg[DATA_W +: ADDR_W] : rdFrame[ADDR_W-1:0];
    strobe.data    = shiftReg[DATA_W-1:0];
  end

  assign tdo = shiftReg[0];

  // R10
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(captureDr && userSel) |-> (bitCnt == '0));
  // R10
  sel_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !userSel |=> $stable(shiftReg));
endmodule

// File: rtl/jubBank.sv
module jubBank
  import jubPkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int DROP_W     = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  bankStrobeT                  strobe,
  input  logic                        resValid,
  input  logic [DATA_W-1:0]           resData,
  output logic [DATA_W-1:0]           readWord,
  output logic [JOB_WORDS*DATA_W-1:0] jobWords,
  output logic                        jobStart,
  output logic [6:0]                  clkMult,
  output logic [DROP_W-1:0]           dropCnt
);
  logic [DATA_W-1:0] jobReg [JOB_WORDS];
  logic [ADDR_W-1:0] rdAddr, jobIdx;
  logic [DATA_W-1:0] popHold, fifoHead;
  logic fifoEmpty, popEn, clkWrOk;

  for (genvar gi = 0; gi < JOB_WORDS; gi++) begin : g_job
    always_ff @(posedge clk) begin
      if (!rstN) jobReg[gi] <= '0;
      else if (strobe.wrEn && strobe.addr == ADDR_W'(gi + 1)) jobReg[gi] <= strobe.data;
    end
    assign jobWords[gi*DATA_W +: DATA_W] = jobReg[gi];

    // R2
    word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$past(strobe.wrEn) |-> $stable(jobReg[gi]));
  end

  assign popEn   = strobe.rdReqEn && (strobe.addr == ADDR_POP);
  assign clkWrOk = strobe.wrEn && (strobe.addr == ADDR_CLK) &&
                   (strobe.data >= DATA_W'(CLK_MIN_MHZ)) && (strobe.data <= DATA_W'(CLK_MAX_MHZ));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddr   <= '0;
      popHold  <= '1;
      clkMult  <= CLK_RST_MULT;
      jobStart <= 1'b0;
    end else begin
      if (strobe.rdReqEn) rdAddr <= strobe.addr;
      if (popEn) popHold <= fifoEmpty ? '1 : fifoHead;
      if (clkWrOk) clkMult <= strobe.data[7:1];
      jobStart <= strobe.wrEn && (strobe.addr == ADDR_JOB_HI);
    end
  end

  jubFifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W), .DROP_W(DROP_W)) u_fifo (
    .clk(clk), .rstN(rstN), .push(resValid), .pushData(resData), .pop(popEn),
    .empty(fifoEmpty), .head(fifoHead), .dropCnt(dropCnt));

  assign jobIdx = rdAddr - ADDR_JOB_LO;

  always_comb begin
    if (rdAddr >= ADDR_JOB_LO && rdAddr <= ADDR_JOB_HI) readWord = jobReg[jobIdx];
    else if (rdAddr == ADDR_CLK) readWord = {{(DATA_W-8){1'b0}}, clkMult, 1'b0};
    else if (rdAddr == ADDR_POP) readWord = popHold;
    else                         readWord = '0;
  end

  // R6
  clk_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkMult >= 7'(CLK_MIN_MHZ/2)) && (clkMult <= 7'(CLK_MAX_MHZ/2)));
  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    jobStart |=> !jobStart);
endmodule

// File: rtl/jtagUserBank.sv
module jtagUserBank
  import jubPkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int DROP_W     = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        userSel,
  input  logic                        captureDr,
  input  logic                        shiftDr,
  input  logic                        updateDr,
  input  logic                        tdi,
  output logic                        tdo,
  input  logic                        resValid,
  input  logic [DATA_W-1:0]           resData,
  output logic [JOB_WORDS*DATA_W-1:0] jobWords,
  output logic                        jobStart,
  output logic [6:0]                  clkMult,
  output logic [DROP_W-1:0]           dropCnt
);
  bankStrobeT        strobe;
  logic [DATA_W-1:0] readWord;

  jubCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .userSel(userSel), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .tdi(tdi), .readWord(readWord),
    .tdo(tdo), .strobe(strobe));

  jubBank #(.FIFO_DEPTH(FIFO_DEPTH), .DROP_W(DROP_W)) u_bank (
    .clk(clk), .rstN(rstN), .strobe(strobe), .resValid(resValid), .resData(resData),
    .readWord(readWord), .jobWords(jobWords), .jobStart(jobStart),
    .clkMult(clkMult), .dropCnt(dropCnt));
endmodule

// File: tb/jtagUserBank_bench.sv
`timescale 1ns/1ps
module jtagUserBank_bench;
  logic clk = 0, rstN = 0, userSel = 0, captureDr = 0, shiftDr = 0, updateDr = 0, tdi = 0;
  logic resValid = 0;
  logic [31:0] resData = '0;
  logic tdo, jobStart;
  logic [351:0] jobWords;
  logic [6:0] clkMult;
  logic [7:0] dropCnt;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  jtagUserBank u_jtagUserBank (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [37:0] mkWr(input logic [3:0] a, input logic [31:0] d,
                                       input logic flag, input logic bad);
    logic [37:0] f;
    f = {1'b0, flag, a, d};
    f[37] = ~(^f[36:0]) ^ bad;
    return f;
  endfunction

  function automatic logic [37:0] mkRd(input logic [3:0] a, input logic flag, input logic bad);
    logic [37:0] f;
    f = '0;
    f[4:0] = {flag, a};
    f[5] = ~(^f[4:0]) ^ bad;
    return f;
  endfunction

  function automatic logic [31:0] pat(input int a);
    return 32'h9E3779B9 * (a + 1);
  endfunction

  task automatic scan(input int n, input logic [37:0] din, input logic sel, output logic [37:0] dout);
    dout = '0;
    @(negedge clk); userSel = sel; captureDr = 1;
    @(negedge clk); captureDr = 0;
    for (int k = 0; k < n; k++) begin
      shiftDr = 1; tdi = din[k]; dout[k] = tdo;
      @(negedge clk);
    end
    shiftDr = 0; updateDr = 1;
    @(negedge clk); updateDr = 0; userSel = 1;
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    logic [37:0] o;
    scan(38, mkWr(a, d, 1'b1, 1'b0), 1'b1, o);
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [31:0] v);
    logic [37:0] o;
    scan(6, mkRd(a, 1'b0, 1'b0), 1'b1, o);
    scan(32, '0, 1'b1, o);
    v = o[31:0];
  endtask

  task automatic pushRes(input logic [31:0] d);
    @(negedge clk); resValid = 1; resData = d;
    @(negedge clk); resValid = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [37:0] o;
    logic [6:0] expMult;
    int vals [8] = '{2, 7, 1, 0, 250, 251, 255, 100};
    repeat (4) @(negedge clk);
    rstN = 1; userSel = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 jobWords", jobWords[31:0] | jobWords[351:320], 32'h0);
    chk("R1 jobStart", {31'b0, jobStart}, 32'h0);
    chk("R1 dropCnt", {24'b0, dropCnt}, 32'h0);
    rdReg(4'd13, v); chk("R1 clock 200", v, 32'd200);
    rdReg(4'd14, v); chk("R1 empty pop", v, 32'hFFFFFFFF);

    // R2 / R8 sweep over addresses
    for (int a = 0; a < 16; a++)
      if (a != 13 && a != 14) wrReg(4'(a), pat(a));
    for (int a = 0; a < 16; a++) begin
      if (a == 13 || a == 14) continue;
      rdReg(4'(a), v);
      if (a >= 1 && a <= 11) begin
        chk($sformatf("R2 R3 readback a=%0d", a), v, pat(a));
        chk($sformatf("R2 jobWords a=%0d", a), jobWords[(a-1)*32 +: 32], pat(a));
      end else chk($sformatf("R8 unmapped a=%0d", a), v, 32'h0);
    end

    // R5 job start pulse
    wrReg(4'd11, 32'h1234_5678);
    chk("R5 pulse high", {31'b0, jobStart}, 32'h1);
    @(negedge clk);
    chk("R5 pulse one cycle", {31'b0, jobStart}, 32'h0);
    wrReg(4'd10, 32'h0BAD_F00D);
    chk("R5 no pulse a=10", {31'b0, jobStart}, 32'h0);

    // R6 clock register
    expMult = 7'd100;
    foreach (vals[i]) begin
      wrReg(4'd13, 32'(vals[i]));
      if (vals[i] >= 2 && vals[i] <= 250) expMult = 7'(vals[i] >> 1);
      chk($sformatf("R6 clkMult v=%0d", vals[i]), {25'b0, clkMult}, {25'b0, expMult});
      rdReg(4'd13, v);
      chk($sformatf("R6 read v=%0d", vals[i]), v, {24'b0, expMult, 1'b0});
    end

    // R4 bad parity write
    scan(38, mkWr(4'd3, 32'hDEAD_BEEF, 1'b1, 1'b1), 1'b1, o);
    chk("R4 bad parity write", jobWords[2*32 +: 32], pat(3));
    // R11 write flag clear in long frame
    scan(38, mkWr(4'd3, 32'hDEAD_BEEF, 1'b0, 1'b0), 1'b1, o);
    chk("R11 flag clear write", jobWords[2*32 +: 32], pat(3));
    // R10 wrong length, deselected, no update
    scan(37, mkWr(4'd3, 32'hDEAD_BEEF, 1'b1, 1'b0), 1'b1, o);
    chk("R10 37-bit frame", jobWords[2*32 +: 32], pat(3));
    scan(38, mkWr(4'd3, 32'hDEAD_BEEF, 1'b1, 1'b0), 1'b0, o);
    chk("R10 userSel low", jobWords[2*32 +: 32], pat(3));
    begin
      logic [37:0] f;
      f = mkWr(4'd3, 32'hDEAD_BEEF, 1'b1, 1'b0);
      @(negedge clk); captureDr = 1;
      @(negedge clk); captureDr = 0;
      for (int k = 0; k < 38; k++) begin
        shiftDr = 1; tdi = f[k];
        @(negedge clk);
      end
      shiftDr = 0;
      @(negedge clk);
      chk("R10 shifted no update", jobWords[2*32 +: 32], pat(3));
    end
    rdReg(4'd3, v); chk("R10 still old", v, pat(3));

    // R9 fill FIFO past depth 4
    for (int i = 0; i < 6; i++) pushRes(32'hC0DE_0000 + 32'(i));
    chk("R9 dropCnt", {24'b0, dropCnt}, 32'd2);

    // R4 bad parity read request: no pop, address kept
    scan(6, mkRd(4'd3, 1'b0, 1'b0), 1'b1, o);
    scan(6, mkRd(4'd14, 1'b0, 1'b1), 1'b1, o);
    scan(32, '0, 1'b1, o);
    chk("R4 bad parity read keeps addr", o[31:0], pat(3));
    // R11 short frame with flag set
    scan(6, mkRd(4'd14, 1'b1, 1'b0), 1'b1, o);
    scan(32, '0, 1'b1, o);
    chk("R11 short flag set", o[31:0], pat(3));

    // R7 pop order then empty marker
    for (int i = 0; i < 5; i++) begin
      rdReg(4'd14, v);
      chk($sformatf("R7 pop %0d", i), v, (i < 4) ? 32'hC0DE_0000 + 32'(i) : 32'hFFFFFFFF);
    end
    // R7 FIFO refills after drain
    pushRes(32'hFACE_0001);
    rdReg(4'd14, v); chk("R7 refill pop", v, 32'hFACE_0001);

    // R9 saturation
    for (int i = 0; i < 4; i++) pushRes(32'h1);
    for (int i = 0; i < 260; i++) pushRes(32'h2);
    chk("R9 saturate", {24'b0, dropCnt}, 32'd255);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule